// File: doc/BRIEF.md
# Sized-Access General Register File

This block holds eight 32-bit general-purpose registers. Each access names a register through a 3-bit selector and is sized by two more inputs: an optional width bit, and a flag for a 16-bit or 32-bit operation. From these, every port works out which register is addressed and which byte lanes of it take part.

Byte accesses reach either the low byte or bits 15:8 of the first four registers. Sixteen-bit and 32-bit accesses reach the low half or the whole of any register.

There is one combinational read port, whose result is always zero-extended to 32 bits. There is also one clocked write port. A narrow write merges its right-aligned data into the addressed lanes and leaves every other bit of that register as it was. This lets an instruction datapath use the same storage for byte, half and full-width operands.

Top module: `gpr_sized_file`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all eight registers are cleared to zero by that edge.
- R2: When the width-field-present input is 1 and the width bit is 0, the access is one byte wide, in either operation size.
- R3: In a byte access, selector codes 0..3 address bits 7:0 of registers 0..3.
- R4: In a byte access, selector codes 4..7 address bits 15:8 of registers 0..3, taken in that order.
- R5: When the width field is present and the width bit is 1, the access covers bits 15:0 of register `sel` if the op32 flag is 0, and all 32 bits if it is 1.
- R6: When the width-field-present input is 0, the selector addresses register `sel` at full operation size: 16 bits if op32 is 0, and 32 bits if op32 is 1.
- R7: A byte or 16-bit write changes only the addressed lanes of its target register. Write data is right-aligned: a byte comes from `wr_data[7:0]`, and a half from `wr_data[15:0]`.
- R8: The read output is zero-extended. For a byte access, bits 31:8 are 0, and for a 16-bit access, bits 31:16 are 0.
- R9: A write takes effect at the rising edge only when `wr_en` is 1. A read of the target register in the same cycle returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_reg | input | 3 | Read register selector |
| rd_wfield | input | 1 | Read: a width bit is present |
| rd_wbit | input | 1 | Read: width bit (0 = byte) |
| rd_op32 | input | 1 | Read: 1 = 32-bit operation size |
| rd_data | output | 32 | Zero-extended read value |
| wr_en | input | 1 | Write enable |
| wr_reg | input | 3 | Write register selector |
| wr_wfield | input | 1 | Write: a width bit is present |
| wr_wbit | input | 1 | Write: width bit (0 = byte) |
| wr_op32 | input | 1 | Write: 1 = 32-bit operation size |
| wr_data | input | 32 | Right-aligned write data |

## Verification
The bench fills every register with a distinct pattern. It then reads all eight selector codes under each of the six sizing combinations. A decoder that treated codes 4..7 as whole registers in byte mode would return bytes of registers 4..7 instead of bits 15:8 of registers 0..3. A read port without zero-extension would leak upper bits.

Byte and half writes with both operation sizes follow, each checked by reading back the full register. A design that overwrote instead of merging would clear neighbouring lanes. A disabled write and same-cycle reads of the register being written expose early or unguarded updates.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int XLEN   = 32;
  localparam int NREG   = 8;
  localparam int SEL_W  = $clog2(NREG);
  localparam int LANES  = XLEN / 8;

  typedef enum logic [1:0] {
    ACC_BLO  = 2'd0,
    ACC_BHI  = 2'd1,
    ACC_HALF = 2'd2,
    ACC_WORD = 2'd3
  } acc_kind_t;

  typedef struct packed {
    logic [SEL_W-1:0] idx;
    acc_kind_t        kind;
  } acc_t;

  // selector + sizing inputs -> register index and access kind
  function automatic acc_t decode_access(input logic [SEL_W-1:0] sel,
                                         input logic wfield,
                                         input logic wbit,
                                         input logic op32);
    acc_t a;
    if (wfield && !wbit) begin
      a.idx  = {1'b0, sel[SEL_W-2:0]};
      a.kind = sel[SEL_W-1] ? ACC_BHI : ACC_BLO;
    end else begin
      a.idx  = sel;
      a.kind = op32 ? ACC_WORD : ACC_HALF;
    end
    return a;
  endfunction

  function automatic logic [LANES-1:0] lanes_of(input acc_kind_t k);
    case (k)
      ACC_BLO:  return LANES'(4'b0001);
      ACC_BHI:  return LANES'(4'b0010);
      ACC_HALF: return LANES'(4'b0011);
      default:  return {LANES{1'b1}};
    endcase
  endfunction

  function automatic logic [XLEN-1:0] merge_write(input logic [XLEN-1:0] old_v,
                                                  input logic [XLEN-1:0] din,
                                                  input acc_kind_t k);
    case (k)
      ACC_BLO:  return {old_v[XLEN-1:8], din[7:0]};
      ACC_BHI:  return {old_v[XLEN-1:16], din[7:0], old_v[7:0]};
      ACC_HALF: return {old_v[XLEN-1:16], din[15:0]};
      default:  return din;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] extract_read(input logic [XLEN-1:0] v,
                                                   input acc_kind_t k);
    case (k)
      ACC_BLO:  return {{(XLEN-8){1'b0}}, v[7:0]};
      ACC_BHI:  return {{(XLEN-8){1'b0}}, v[15:8]};
      ACC_HALF: return {{(XLEN-16){1'b0}}, v[15:0]};
      default:  return v;
    endcase
  endfunction
endpackage

// File: rtl/gpr_access_decode.sv
module gpr_access_decode
  import gpr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             wfield,
  input  logic             wbit,
  input  logic             op32,
  output logic [SEL_W-1:0] idx,
  output acc_kind_t        kind,
  output logic [LANES-1:0] lanes
);
  acc_t dec;

  always_comb begin
    dec   = decode_access(sel, wfield, wbit, op32);
    idx   = dec.idx;
    kind  = dec.kind;
    lanes = lanes_of(dec.kind);
  end

  // R2: byte access touches exactly one lane in either op size
  a_r2_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (wfield && !wbit) |-> ($countones(lanes) == 1));

  // R3: low-byte codes map to lane 0 of registers 0..3
  a_r3_low_byte_map: assert property (@(posedge clk) disable iff (!rst_n)
    (wfield && !wbit && !sel[SEL_W-1]) |-> (lanes[0] && idx[SEL_W-1] == 1'b0
                                            && idx[SEL_W-2:0] == sel[SEL_W-2:0]));

  // R4: high-byte codes map to lane 1 of registers 0..3
  a_r4_high_byte_map: assert property (@(posedge clk) disable iff (!rst_n)
    (wfield && !wbit && sel[SEL_W-1]) |-> (lanes[1] && !lanes[0] && idx[SEL_W-1] == 1'b0));

  // R5/R6: full-size accesses keep the selector and follow op32
  a_r5_full_width: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wfield && !wbit) && op32) |-> (&lanes && idx == sel));
  a_r6_half_width: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wfield && !wbit) && !op32) |-> (lanes[1:0] == 2'b11 && !lanes[LANES-1] && idx == sel));
endmodule

// File: rtl/gpr_write_bank.sv
module gpr_write_bank
  import gpr_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [SEL_W-1:0]           wr_idx,
  input  acc_kind_t                  wr_kind,
  input  logic [LANES-1:0]           wr_lanes,
  input  logic [XLEN-1:0]            wr_data,
  output logic [NREG-1:0][XLEN-1:0]  regs
);
  logic [NREG-1:0] hit;
  logic [XLEN-1:0] bitmask;

  genvar gl;
  generate
    for (gl = 0; gl < LANES; gl++) begin : g_mask
      assign bitmask[gl*8 +: 8] = {8{wr_lanes[gl]}};
    end
  endgenerate

  genvar gr;
  generate
    for (gr = 0; gr < NREG; gr++) begin : g_reg
      assign hit[gr] = wr_en && (wr_idx == SEL_W'(gr));

      always_ff @(posedge clk) begin
        if (!rst_n)       regs[gr] <= '0;
        else if (hit[gr]) regs[gr] <= merge_write(regs[gr], wr_data, wr_kind);
      end

      // R1: reset clears every register
      a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (regs[gr] == '0));

      // R9: no write without enable and address match
      a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !hit[gr] |=> $stable(regs[gr]));

      // R7: bits outside the addressed lanes survive a write
      a_r7_unselected_kept: assert property (@(posedge clk) disable iff (!rst_n)
        hit[gr] |=> (((regs[gr] ^ $past(regs[gr])) & ~$past(bitmask)) == '0));
    end
  endgenerate
endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port
  import gpr_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NREG-1:0][XLEN-1:0] regs,
  input  logic [SEL_W-1:0]          rd_idx,
  input  acc_kind_t                 rd_kind,
  input  logic [LANES-1:0]          rd_lanes,
  output logic [XLEN-1:0]           rd_data
);
  logic [XLEN-1:0] picked;

  always_comb begin
    picked  = regs[rd_idx];
    rd_data = extract_read(picked, rd_kind);
  end

  // R8: zero-extension of narrow reads
  a_r8_byte_zext: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(rd_lanes) == 1) |-> (rd_data[XLEN-1:8] == '0));
  a_r8_half_zext: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lanes == LANES'(4'b0011)) |-> (rd_data[XLEN-1:16] == '0));
endmodule

// File: rtl/gpr_sized_file.sv
module gpr_sized_file
  import gpr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] rd_reg,
  input  logic             rd_wfield,
  input  logic             rd_wbit,
  input  logic             rd_op32,
  output logic [XLEN-1:0]  rd_data,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_reg,
  input  logic             wr_wfield,
  input  logic             wr_wbit,
  input  logic             wr_op32,
  input  logic [XLEN-1:0]  wr_data
);
  logic [SEL_W-1:0]          rd_idx, wr_idx;
  acc_kind_t                 rd_kind, wr_kind;
  logic [LANES-1:0]          rd_lanes, wr_lanes;
  logic [NREG-1:0][XLEN-1:0] regs;

  gpr_access_decode u_rd_dec (
    .clk(clk), .rst_n(rst_n), .sel(rd_reg), .wfield(rd_wfield), .wbit(rd_wbit),
    .op32(rd_op32), .idx(rd_idx), .kind(rd_kind), .lanes(rd_lanes));

  gpr_access_decode u_wr_dec (
    .clk(clk), .rst_n(rst_n), .sel(wr_reg), .wfield(wr_wfield), .wbit(wr_wbit),
    .op32(wr_op32), .idx(wr_idx), .kind(wr_kind), .lanes(wr_lanes));

  gpr_write_bank u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_kind(wr_kind),
    .wr_lanes(wr_lanes), .wr_data(wr_data), .regs(regs));

  gpr_read_port u_rd (
    .clk(clk), .rst_n(rst_n), .regs(regs), .rd_idx(rd_idx), .rd_kind(rd_kind),
    .rd_lanes(rd_lanes), .rd_data(rd_data));
endmodule

// File: tb/tb_gpr_sized_file.sv
module tb_gpr_sized_file;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  rd_reg = '0;
  logic        rd_wfield = 1'b0, rd_wbit = 1'b0, rd_op32 = 1'b0;
  logic [31:0] rd_data;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_reg = '0;
  logic        wr_wfield = 1'b0, wr_wbit = 1'b0, wr_op32 = 1'b0;
  logic [31:0] wr_data = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] model [8];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;  // 50 MHz

  gpr_sized_file dut (
    .clk(clk), .rst_n(rst_n), .rd_reg(rd_reg), .rd_wfield(rd_wfield),
    .rd_wbit(rd_wbit), .rd_op32(rd_op32), .rd_data(rd_data), .wr_en(wr_en),
    .wr_reg(wr_reg), .wr_wfield(wr_wfield), .wr_wbit(wr_wbit),
    .wr_op32(wr_op32), .wr_data(wr_data));

  // reference read: byte codes 0..3 -> bits 7:0, 4..7 -> bits 15:8 of regs 0..3
  function automatic logic [31:0] ref_read(input int s, input bit wf, input bit wb, input bit o32);
    if (wf && !wb) begin
      if (s >= 4) return {24'h0, model[s-4][15:8]};
      return {24'h0, model[s][7:0]};
    end
    if (o32) return model[s];
    return {16'h0, model[s][15:0]};
  endfunction

  task automatic ref_write(input int s, input bit wf, input bit wb, input bit o32,
                           input logic [31:0] d);
    if (wf && !wb) begin
      if (s >= 4) model[s-4][15:8] = d[7:0];
      else        model[s][7:0]    = d[7:0];
    end else if (o32) model[s] = d;
    else model[s][15:0] = d[15:0];
  endtask

  task automatic do_read(input int s, input bit wf, input bit wb, input bit o32, input string tag);
    @(negedge clk);
    wr_en = 1'b0;
    rd_reg = 3'(s); rd_wfield = wf; rd_wbit = wb; rd_op32 = o32;
    exp_q.push_back(ref_read(s, wf, wb, o32));
    tag_q.push_back(tag);
  endtask

  // write, while reading the whole target register in the same cycle (R9: old value)
  task automatic do_write(input bit en, input int s, input bit wf, input bit wb, input bit o32,
                          input logic [31:0] d);
    int tgt;
    tgt = (wf && !wb) ? (s % 4) : s;
    @(negedge clk);
    wr_en = en; wr_reg = 3'(s); wr_wfield = wf; wr_wbit = wb; wr_op32 = o32; wr_data = d;
    rd_reg = 3'(tgt); rd_wfield = 1'b0; rd_wbit = 1'b0; rd_op32 = 1'b1;
    exp_q.push_back(model[tgt]);
    tag_q.push_back("R9 same-cycle read");
    if (en) ref_write(s, wf, wb, o32, d);
  endtask

  task automatic sweep(input string phase);
    for (int s = 0; s < 8; s++) begin
      do_read(s, 1, 0, 0, (s < 4) ? {"R3/R2 byte op16 ", phase} : {"R4/R2 byte op16 ", phase});
      do_read(s, 1, 0, 1, (s < 4) ? {"R3/R2/R8 byte op32 ", phase} : {"R4/R2/R8 byte op32 ", phase});
      do_read(s, 1, 1, 0, {"R5/R8 w1 op16 ", phase});
      do_read(s, 1, 1, 1, {"R5 w1 op32 ", phase});
      do_read(s, 0, 0, 0, {"R6/R8 no-w op16 ", phase});
      do_read(s, 0, 1, 1, {"R6 no-w op32 ", phase});
    end
  endtask

  // monitor: scoreboard pop and compare, mid low phase
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (exp_q.size() > 0) begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (rd_data !== e) begin
          errors++;
          $display("FAIL %s: got %08h expected %08h", t, rd_data, e);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int s = 0; s < 8; s++) do_read(s, 0, 1, 1, "R1 reset value");

    for (int s = 0; s < 8; s++)
      do_write(1, s, 0, 0, 1, 32'h9E37_79B9 ^ (32'h0102_0408 * (s + 1)));
    sweep("after full writes");

    for (int s = 0; s < 8; s++)
      do_write(1, s, 1, 0, s[0], 32'hFFFF_FF00 | (8'hC0 + s));  // R7 byte merge
    for (int s = 0; s < 4; s++) do_read(s, 0, 1, 1, "R7 byte write keeps other lanes");

    do_write(1, 5, 1, 1, 0, 32'hDEAD_5A5A);  // R7 half merge
    do_write(1, 0, 0, 1, 0, 32'hBEEF_1234);
    do_write(0, 3, 0, 1, 1, 32'h0BAD_0BAD);  // R9 disabled write
    do_read(5, 0, 1, 1, "R7 half write keeps bits 31:16");
    do_read(0, 0, 1, 1, "R7 half write keeps bits 31:16");
    do_read(3, 0, 1, 1, "R9 disabled write ignored");
    sweep("after narrow writes");

    @(negedge clk);
    @(negedge clk);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule